// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. It runs the sixteen-state test controller from a test clock and a mode input. It holds a seven-bit instruction register and decodes the current instruction. The decode picks the data register that sits between the serial input and the serial output, and it drives two pin-control modes. The data registers are a one-bit bypass stage, a 32-bit identification register, and an external boundary register. The boundary register is reached through shift, capture and update strobes and a pair of serial lines.

The serial path is a bit stream with no back-pressure. One bit moves on every rising test-clock edge while the controller sits in a shift state. Neither side can stall the stream: the test clock is the only pacing, so no valid/ready pair exists. Every opcode that is not one of the defined instructions falls back to the bypass stage. This covers the reserved code, the whole private class and any other undefined pattern.

Top module: `tap_ctrl`

## Requirements
- R1: The controller follows the sixteen-state test sequence, moving on the rising edge of `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. `trst_n` low forces Test-Logic-Reset at once, without a clock.
- R2: In Test-Logic-Reset the instruction becomes the identification opcode 1111011. While that instruction is current, a data scan shifts out the 32-bit `ID_CODE` value, least significant bit first.
- R3: In Capture-IR the instruction shift stage loads 01 into its two lowest bits and zero into the rest. These bits are the first to leave on `tdo`, the lowest bit first.
- R4: A newly shifted opcode takes effect only when the controller passes through Update-IR. Until then, the current instruction and its pin controls keep their values.
- R5: Opcode 1111111 (bypass) places a one-bit stage between `tdi` and `tdo`. The stage captures 0 in Capture-DR, so a data scan returns 0 followed by `tdi` delayed by one bit.
- R6: Opcodes 1111000 and 1111010 select the external boundary register. In the matching data states `bnd_capture`, `bnd_shift` and `bnd_update` pulse, `bnd_si` carries `tdi`, and `bnd_so` reaches `tdo`. Opcode 1111000 also raises `pins_from_bnd`.
- R7: Opcode 1111101 selects the bypass stage and holds `pins_hiz` high for as long as it is the current instruction.
- R8: Opcode 1111110 selects the bypass stage and holds `pins_from_bnd` high for as long as it is the current instruction.
- R9: The following codes all act exactly like bypass, with both pin controls low: the reserved code 1111001, any code whose low three bits are 100, and every other undefined code.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only for the half cycle that follows a falling edge in Shift-IR or Shift-DR.
- R11: The instruction and data shift stages move on the rising edge of `tck`. They shift toward the least significant bit, and `tdi` enters at the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for tdo |
| bnd_capture | output | 1 | Boundary register capture strobe |
| bnd_shift | output | 1 | Boundary register shift strobe |
| bnd_update | output | 1 | Boundary register update strobe |
| bnd_si | output | 1 | Serial data into the boundary register |
| bnd_so | input | 1 | Serial data from the boundary register |
| pins_hiz | output | 1 | Tri-state all pins |
| pins_from_bnd | output | 1 | Drive pins from the boundary update latches |

## Verification
The assertions check several things on every clock. Five high `tms` samples always land in Test-Logic-Reset. Capture-IR always leaves 01 in the low bits. The instruction never changes outside Update-IR or Test-Logic-Reset. The bypass stage always holds 0 after Capture-DR. `tdo_en` is never high outside a shift state. The two pin controls are never high together, and the boundary strobes never overlap. Only the bench's scans can show the opcode decode and the exact bit streams. This covers the identification value, the bypass delay, the boundary round trip and the fallback of reserved, private and undefined codes.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 7;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SH, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SH, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BND} dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     hiz;
    logic     drive_bnd;
  } instr_dec_t;

  localparam logic [IR_W-1:0] OP_EXTEST = 7'b1111000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 7'b1111010;
  localparam logic [IR_W-1:0] OP_IDCODE = 7'b1111011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 7'b1111101;
  localparam logic [IR_W-1:0] OP_CLAMP  = 7'b1111110;
  localparam logic [IR_W-1:0] OP_BYPASS = 7'b1111111;
  localparam logic [2:0]      PRIV_LOW  = 3'b100;

  // Every unlisted code, the reserved one and the private class: bypass, no pin control.
  function automatic instr_dec_t decode_op(logic [IR_W-1:0] op);
    instr_dec_t d;
    d = '{path: PATH_BYP, hiz: 1'b0, drive_bnd: 1'b0};
    if (op[2:0] != PRIV_LOW) begin
      case (op)
        OP_EXTEST: d = '{path: PATH_BND, hiz: 1'b0, drive_bnd: 1'b1};
        OP_SAMPLE: d = '{path: PATH_BND, hiz: 1'b0, drive_bnd: 1'b0};
        OP_IDCODE: d = '{path: PATH_ID,  hiz: 1'b0, drive_bnd: 1'b0};
        OP_HIGHZ:  d = '{path: PATH_BYP, hiz: 1'b1, drive_bnd: 1'b0};
        OP_CLAMP:  d = '{path: PATH_BYP, hiz: 1'b0, drive_bnd: 1'b1};
        default:   d = '{path: PATH_BYP, hiz: 1'b0, drive_bnd: 1'b0};
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: nxt = tms ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: nxt = tms ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_SH:  nxt = tms ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_EX1: nxt = tms ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: nxt = tms ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: nxt = tms ? ST_DR_UPD : ST_DR_SH;
      ST_DR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: nxt = tms ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: nxt = tms ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_SH:  nxt = tms ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_EX1: nxt = tms ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: nxt = tms ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: nxt = tms ? ST_IR_UPD : ST_IR_SH;
      ST_IR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

  // R1: five high tms samples always end in Test-Logic-Reset
  p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)
    |=> state == ST_RESET);
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);
  localparam logic [IR_W-1:0] CAP_VAL = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ir_sr <= CAP_VAL;
    else if (state == ST_IR_CAP) ir_sr <= CAP_VAL;
    else if (state == ST_IR_SH)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ir_q <= OP_IDCODE;
    else if (state == ST_RESET)  ir_q <= OP_IDCODE;
    else if (state == ST_IR_UPD) ir_q <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];

  // R3: capture pattern in the low bits
  p_cap_ir_r3: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_IR_CAP |=> ir_sr[1:0] == 2'b01);
  // R4: instruction changes only through Update-IR or reset
  p_ir_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_IR_UPD) && (state != ST_RESET) |=> $stable(ir_q));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1234_5679
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  dr_path_e   path,
  input  logic       tdi,
  input  logic       bnd_so,
  output logic       bnd_capture,
  output logic       bnd_shift,
  output logic       bnd_update,
  output logic       dr_lsb
);
  logic            byp_q;
  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) byp_q <= 1'b0;
    else if (path == PATH_BYP) begin
      if (state == ST_DR_CAP)     byp_q <= 1'b0;
      else if (state == ST_DR_SH) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) id_sr <= ID_CODE;
    else if (path == PATH_ID) begin
      if (state == ST_DR_CAP)     id_sr <= ID_CODE;
      else if (state == ST_DR_SH) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  assign bnd_capture = (path == PATH_BND) && (state == ST_DR_CAP);
  assign bnd_shift   = (path == PATH_BND) && (state == ST_DR_SH);
  assign bnd_update  = (path == PATH_BND) && (state == ST_DR_UPD);

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_sr[0];
      PATH_BND: dr_lsb = bnd_so;
      default:  dr_lsb = byp_q;
    endcase
  end

  // R5: bypass stage holds zero right after capture
  p_byp_capture_r5: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_DR_CAP && path == PATH_BYP |=> byp_q == 1'b0);
  // R6: boundary strobes never overlap
  p_bnd_strobe_r6: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bnd_capture, bnd_shift, bnd_update}));
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1234_5679
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update,
  output logic bnd_si,
  input  logic bnd_so,
  output logic pins_hiz,
  output logic pins_from_bnd
);
  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb;
  logic            dr_lsb;
  instr_dec_t      dec;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
               .ir_q(ir_q), .ir_lsb(ir_lsb));

  assign dec = decode_op(ir_q);

  tap_dr #(.ID_W(ID_W), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .path(dec.path), .tdi(tdi),
    .bnd_so(bnd_so), .bnd_capture(bnd_capture), .bnd_shift(bnd_shift),
    .bnd_update(bnd_update), .dr_lsb(dr_lsb));

  assign bnd_si        = tdi;
  assign pins_hiz      = dec.hiz;
  assign pins_from_bnd = dec.drive_bnd;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_IR_SH) || (state == ST_DR_SH);
      tdo    <= (state == ST_IR_SH) ? ir_lsb : dr_lsb;
    end
  end

  // R10: output enabled only while shifting
  p_tdo_en_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_IR_SH) || (state == ST_DR_SH));
  // R7 / R8: the two pin modes never both active
  p_pin_modes_r7: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({pins_hiz, pins_from_bnd}));
endmodule

// File: tb/tap_ctrl_tb.sv
module tap_ctrl_tb;
  localparam logic [31:0] IDV  = 32'h1234_5679;
  localparam logic [7:0]  BCAP = 8'hA5;
  localparam int          NB   = 40;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, bnd_capture, bnd_shift, bnd_update, bnd_si, bnd_so;
  logic pins_hiz, pins_from_bnd;
  logic [7:0] breg = 8'h00;
  int upd_cnt = 0;
  int total = 0, bad = 0;

  always #10 tck = ~tck;

  tap_ctrl #(.ID_CODE(IDV)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update),
    .bnd_si(bnd_si), .bnd_so(bnd_so), .pins_hiz(pins_hiz), .pins_from_bnd(pins_from_bnd));

  // external 8-bit boundary register model
  assign bnd_so = breg[0];
  always @(posedge tck) begin
    if (bnd_capture)    breg <= BCAP;
    else if (bnd_shift) breg <= {bnd_si, breg[7:1]};
    if (bnd_update)     upd_cnt <= upd_cnt + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one TCK cycle: read tdo after the falling edge, then drive inputs for the next rising edge
  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_en;
    tms = m; tdi = d;
  endtask

  task automatic go(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  task automatic shift_ir(input logic [6:0] code, input bit upd, output logic [6:0] cap);
    logic o, oe;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 7; i++) begin
      step(i == 6, code[i], o, oe);
      cap[i] = o;
    end
    if (upd) begin go(1); go(0); go(0); end
  endtask

  task automatic shift_dr(input logic [63:0] din, output logic [63:0] dout, output int en_cnt);
    logic o, oe;
    en_cnt = 0;
    dout = '0;
    go(1); go(0); go(0);
    for (int i = 0; i < NB; i++) begin
      step(i == NB - 1, din[i], o, oe);
      dout[i] = o;
      if (oe) en_cnt++;
    end
    go(1); go(0); go(0);
  endtask

  function automatic logic [63:0] expect_dr(input int kind, input logic [63:0] din);
    logic [63:0] e;
    e = '0;
    for (int i = 0; i < NB; i++) begin
      case (kind)
        1: e[i] = (i < 32) ? IDV[i]  : din[i-32];
        2: e[i] = (i < 8)  ? BCAP[i] : din[i-8];
        default: e[i] = (i < 1) ? 1'b0 : din[i-1];
      endcase
    end
    return e;
  endfunction

  // {opcode, kind(0 byp,1 id,2 bnd), hiz, drive}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {7'b1111000, 2'd2, 1'b0, 1'b1},  // R6 EXTEST
    {7'b1111010, 2'd2, 1'b0, 1'b0},  // R6 sample
    {7'b1111011, 2'd1, 1'b0, 1'b0},  // R2 id
    {7'b1111111, 2'd0, 1'b0, 1'b0},  // R5 bypass
    {7'b1111101, 2'd0, 1'b1, 1'b0},  // R7 hiz
    {7'b1111110, 2'd0, 1'b0, 1'b1},  // R8 clamp
    {7'b1111001, 2'd0, 1'b0, 1'b0},  // R9 reserved
    {7'b0000100, 2'd0, 1'b0, 1'b0},  // R9 private
    {7'b1111100, 2'd0, 1'b0, 1'b0},  // R9 private
    {7'b1010100, 2'd0, 1'b0, 1'b0},  // R9 private
    {7'b0110011, 2'd0, 1'b0, 1'b0},  // R9 undefined
    {7'b0000000, 2'd0, 1'b0, 1'b0}   // R9 undefined
  };

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0]  cap;
    logic [63:0] dout, din;
    int          en, u0;
    #35 trst_n = 1'b1;
    go(1); go(0);
    // R1 R2 reset state: controls low, output disabled, ID selected
    chk("R2 reset pins", {62'd0, pins_hiz, pins_from_bnd}, 64'd0);
    chk("R10 reset tdo_en", {63'd0, tdo_en}, 64'd0);
    din = 64'h0000_00C3_5A0F_96E1;
    shift_dr(din, dout, en);
    chk("R2 id after reset", dout, expect_dr(1, din));
    chk("R10 tdo_en count DR", en, NB);

    // main table walk
    for (int v = 0; v < NV; v++) begin
      logic [6:0] op;
      int         kind;
      op = VEC[v][10:4];
      kind = int'(VEC[v][3:2]);
      shift_ir(op, 1, cap);
      chk("R3 capture-ir bits", {62'd0, cap[1:0]}, 64'd1);
      chk("R7 R8 pin controls", {62'd0, pins_hiz, pins_from_bnd}, {62'd0, VEC[v][1:0]});
      u0 = upd_cnt;
      din = 64'hFEED_0000_0000 ^ (64'h1357_9BDF_0246 << v);
      shift_dr(din, dout, en);
      chk(kind == 2 ? "R6 boundary path" : kind == 1 ? "R2 id path" : "R5 R9 bypass path",
          dout, expect_dr(kind, din));
      chk("R6 update strobes", upd_cnt - u0, (kind == 2) ? 1 : 0);
    end

    // R4: opcode waits for Update-IR
    shift_ir(7'b1111111, 1, cap);
    shift_ir(7'b1111101, 0, cap);
    chk("R4 no early hiz", {63'd0, pins_hiz}, 64'd0);
    go(1); go(0); go(0);
    chk("R4 hiz after update", {63'd0, pins_hiz}, 64'd1);

    // R1: five TMS-high cycles from RTI restore ID instruction
    for (int k = 0; k < 5; k++) go(1);
    go(0);
    chk("R1 tms reset pins", {63'd0, pins_hiz}, 64'd0);
    din = 64'h55;
    shift_dr(din, dout, en);
    chk("R1 tms reset id", dout, expect_dr(1, din));

    // R1: asynchronous trst_n mid-scan
    shift_ir(7'b1111110, 1, cap);
    chk("R8 clamp set", {63'd0, pins_from_bnd}, 64'd1);
    #3 trst_n = 1'b0;
    #2;
    chk("R1 async reset", {62'd0, pins_hiz, pins_from_bnd}, 64'd0);
    #5 trst_n = 1'b1;
    go(1); go(0);

    // R11 R3: IR scan out order after capture (LSB first, 01 then zeros)
    shift_ir(7'b1111111, 1, cap);
    chk("R11 ir scan order", {57'd0, cap}, 64'd1);
    // R10: tdo_en low in idle
    go(0);
    chk("R10 idle tdo_en", {63'd0, tdo_en}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule